// File: doc/BRIEF.md
# Latched Trigger Receiver Register

This block sits in every readout crate and tells the local readout processor that a trigger of some kind has arrived. Sixteen asynchronous input lines are brought into the clock domain by a synchroniser and then watched for rising edges. The low eight channels are latching channels. A rising edge sets a latch bit, and that bit stays set until software clears it. The high eight channels carry plain status levels that every crate receives, such as the dead-time gate and the aggregated all-busy lines. Software sees these as synchronised levels.

Four latching channels carry the trigger classes. Each class has its own local busy line. A trigger sets the latch for its class, which software clears as soon as it has seen the trigger. The same trigger also sets the class busy, which software clears only when readout is done. An idle output shows that no busy is active. An event-type tag reports which class fired last. A second trigger that arrives for a class whose busy is still set raises a sticky overlap error, so a crate that has lost step with the others shows up at once.

A simple register port reads and clears the latches, the busy lines and the error flags, and writes a 16-bit output register. Bit 0 of the output register is routed back in place of input channel 1, so software can exercise the latch path without any external stimulus. The register port is a control path. It is always ready, it applies no back-pressure, and a read returns data one cycle after it is issued.

Top module: `trig_rx_reg`

## Requirements
- R1: After reset all latch bits, busy lines, overlap errors, the output register and the read data are zero, and `idle_o` is 1.
- R2: On a latching channel (0 to 7), a rising edge of the synchronised input sets that channel's bit at register address 0. The bit stays set until it is cleared. An input held high sets the bit only once, so after a clear the bit stays 0 even while the input is still high.
- R3: A write to address 0 clears every latch bit that has a 1 in the write data (write-1-to-clear). If a new edge and a clear reach the same bit in the same cycle, the bit ends up set.
- R4: Channels 8 to 15 never latch; their bits at address 0 read 0. Address 3 returns the synchronised level of all 16 channels.
- R5: A write to address 1 loads the output register. `out_reg_o` and a read of address 1 both return the value written. Output bit 0 replaces input `trig_in[1]` as channel 1, so a 0-to-1 change of output bit 0 sets latch bit 1, and `trig_in[1]` has no effect.
- R6: Trigger class k (0 = physics event, 1 = calibration, 2 = start of spill, 3 = end of spill) is latching channel 4+k. A rising edge on that channel sets `busy_o[k]`. The busy line stays set until a write to address 2 with data bit k equal to 1.
- R7: `idle_o` is 1 exactly when every bit of `busy_o` is 0.
- R8: A rising edge on class channel 4+k while `busy_o[k]` is already 1 sets the sticky flag `ovl_err_o[k]`. Address 2 reads the busy lines in bits 3:0 and the error flags in bits 7:4. Writing 1 to bit 4+k clears error k.
- R9: `evt_type_o` holds the class number of the most recent class edge. When several class edges arrive in the same cycle, the lowest class number wins. `evt_valid_o` equals NOT `idle_o`.
- R10: A read (`reg_en`=1, `reg_we`=0) puts the addressed value on `reg_rdata` after the next clock edge. `reg_rdata` then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_in | input | 16 | Asynchronous trigger and status inputs |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | 0 latches, 1 output register, 2 busy/error, 3 live levels |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| out_reg_o | output | 16 | Output register contents |
| busy_o | output | 4 | Local busy line, one per trigger class |
| idle_o | output | 1 | No busy line active |
| ovl_err_o | output | 4 | Sticky overlap error, one per class |
| evt_type_o | output | 2 | Class number of the most recent trigger |
| evt_valid_o | output | 1 | Event type is meaningful (some busy is active) |

## Verification
Each fault shows up at the ports within one read of its cause:
- A latch that loses its edge-detector history would re-set after a clear while its input is still held high. The next read of address 0 shows this.
- A clear that wins over a coincident set drops a trigger. The directed same-cycle case catches this at the next read.
- A busy or error flag that resets itself, or a wrong priority in the event encoder, shows on `busy_o`, `ovl_err_o` or `evt_type_o` within the settle window that follows each stimulus.
- A broken loopback shows as a missing latch bit 1 a few cycles after output bit 0 rises.

// File: rtl/trig_rx_pkg.sv
package trig_rx_pkg;

  // Register map of the access port.
  typedef enum logic [1:0] {
    ADDR_LATCH = 2'd0,
    ADDR_OUT   = 2'd1,
    ADDR_BUSY  = 2'd2,
    ADDR_LIVE  = 2'd3
  } trig_addr_e;

endpackage

// File: rtl/trig_rx_sync.sv
module trig_rx_sync #(
  parameter int W      = 16,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];

endmodule

// File: rtl/trig_rx_latch.sv
module trig_rx_latch #(
  parameter int W    = 16,
  parameter int NLAT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] edge_o,
  output logic [W-1:0] lat_o
);

  localparam logic [W-1:0] LMASK = {{(W-NLAT){1'b0}}, {NLAT{1'b1}}};

  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;

  assign edge_o = lvl_i & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= lvl_i;
      // set wins over a clear of the same bit
      lat_q  <= ((lat_q & ~clr_i) | edge_o) & LMASK;
    end
  end

  assign lat_o = lat_q;

  for (genvar g = 0; g < W; g++) begin : g_chk
    if (g < NLAT) begin : g_lat
      assert_edge_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_i[g] && !prev_q[g]) |=> lat_q[g]);
      assert_hold_until_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q[g] && !clr_i[g]) |=> lat_q[g]);
    end else begin : g_plain
      assert_no_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_i[g] |=> !lat_q[g]);
    end
  end

endmodule

// File: rtl/trig_rx_class.sv
module trig_rx_class #(
  parameter int NCLS = 4,
  parameter int TW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCLS-1:0] cls_edge_i,
  input  logic [NCLS-1:0] busy_clr_i,
  input  logic [NCLS-1:0] err_clr_i,
  output logic [NCLS-1:0] busy_o,
  output logic [NCLS-1:0] err_o,
  output logic [TW-1:0]   evt_type_o,
  output logic            idle_o
);

  logic [NCLS-1:0] busy_q, err_q;
  logic [TW-1:0]   evt_q, evt_nxt;

  // lowest class number wins on simultaneous edges
  always_comb begin
    evt_nxt = evt_q;
    for (int k = NCLS-1; k >= 0; k--) begin
      if (cls_edge_i[k]) evt_nxt = TW'(k);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      err_q  <= '0;
      evt_q  <= '0;
    end else begin
      busy_q <= (busy_q & ~busy_clr_i) | cls_edge_i;
      err_q  <= (err_q & ~err_clr_i) | (cls_edge_i & busy_q);
      evt_q  <= evt_nxt;
    end
  end

  assign busy_o     = busy_q;
  assign err_o      = err_q;
  assign evt_type_o = evt_q;
  assign idle_o     = ~|busy_q;

  for (genvar k = 0; k < NCLS; k++) begin : g_chk
    assert_busy_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cls_edge_i[k] |=> busy_q[k]);
    assert_busy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q[k] && !busy_clr_i[k]) |=> busy_q[k]);
    assert_overlap_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_edge_i[k] && busy_q[k]) |=> err_q[k]);
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q[k] && !err_clr_i[k]) |=> err_q[k]);
  end

  assert_evt_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cls_edge_i[0] |=> (evt_q == '0));

endmodule

// File: rtl/trig_rx_reg.sv
module trig_rx_reg
  import trig_rx_pkg::*;
#(
  parameter int NCH     = 16,
  parameter int NLAT    = 8,
  parameter int NCLS    = 4,
  parameter int CLS_BASE = 4,
  parameter int LOOP_CH = 1,
  parameter int SYNC_ST = 2,
  parameter int TW      = $clog2(NCLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH-1:0]  trig_in,
  input  logic            reg_en,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NCH-1:0]  reg_wdata,
  output logic [NCH-1:0]  reg_rdata,
  output logic [NCH-1:0]  out_reg_o,
  output logic [NCLS-1:0] busy_o,
  output logic            idle_o,
  output logic [NCLS-1:0] ovl_err_o,
  output logic [TW-1:0]   evt_type_o,
  output logic            evt_valid_o
);

  logic [NCH-1:0]  raw, lvl, edges, lat;
  logic [NCH-1:0]  out_q, rd_q, rd_nxt, lat_clr;
  logic [NCLS-1:0] busy_clr, err_clr;
  logic            wr, rd;

  assign wr = reg_en &  reg_we;
  assign rd = reg_en & ~reg_we;

  // output bit 0 replaces the loopback input channel
  always_comb begin
    raw          = trig_in;
    raw[LOOP_CH] = out_q[0];
  end

  trig_rx_sync #(.W(NCH), .STAGES(SYNC_ST)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw), .q_o(lvl)
  );

  assign lat_clr  = (wr && reg_addr == ADDR_LATCH) ? reg_wdata : '0;
  assign busy_clr = (wr && reg_addr == ADDR_BUSY) ? reg_wdata[NCLS-1:0] : '0;
  assign err_clr  = (wr && reg_addr == ADDR_BUSY) ? reg_wdata[2*NCLS-1:NCLS] : '0;

  trig_rx_latch #(.W(NCH), .NLAT(NLAT)) u_latch (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl), .clr_i(lat_clr),
    .edge_o(edges), .lat_o(lat)
  );

  trig_rx_class #(.NCLS(NCLS), .TW(TW)) u_class (
    .clk(clk), .rst_n(rst_n),
    .cls_edge_i(edges[CLS_BASE +: NCLS]),
    .busy_clr_i(busy_clr), .err_clr_i(err_clr),
    .busy_o(busy_o), .err_o(ovl_err_o),
    .evt_type_o(evt_type_o), .idle_o(idle_o)
  );

  always_comb begin
    rd_nxt = '0;
    unique case (trig_addr_e'(reg_addr))
      ADDR_LATCH: rd_nxt = lat;
      ADDR_OUT:   rd_nxt = out_q;
      ADDR_BUSY: begin
        rd_nxt[NCLS-1:0]      = busy_o;
        rd_nxt[2*NCLS-1:NCLS] = ovl_err_o;
      end
      ADDR_LIVE:  rd_nxt = lvl;
      default:    rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr && reg_addr == ADDR_OUT) out_q <= reg_wdata;
      if (rd) rd_q <= rd_nxt;
    end
  end

  assign reg_rdata   = rd_q;
  assign out_reg_o   = out_q;
  assign evt_valid_o = ~idle_o;

  assert_out_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && reg_addr == ADDR_OUT) |=> (out_reg_o == $past(reg_wdata)));
  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(reg_rdata));
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle_o) |-> busy_o != '0);

endmodule

// File: tb/trig_rx_reg_tb_top.sv
`timescale 1ns/1ps
module trig_rx_reg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] trig_in = '0;
  logic        reg_en = 1'b0, reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, out_reg_o;
  logic [3:0]  busy_o, ovl_err_o;
  logic        idle_o, evt_valid_o;
  logic [1:0]  evt_type_o;

  int total = 0, bad = 0;

  // bench model
  logic [15:0] m_lat = '0, m_out = '0;
  logic [3:0]  m_busy = '0, m_err = '0;
  logic [1:0]  m_evt = '0;

  always #2.5 clk = ~clk;

  trig_rx_reg dut_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .out_reg_o(out_reg_o),
    .busy_o(busy_o), .idle_o(idle_o), .ovl_err_o(ovl_err_o),
    .evt_type_o(evt_type_o), .evt_valid_o(evt_valid_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input int a);
    case (a)
      0: return m_lat;
      1: return m_out;
      2: return {8'h00, m_err, m_busy};
      default: return '0;
    endcase
  endfunction

  function automatic bit is_latching(input int ch);
    return ch < 8;
  endfunction

  task automatic model_edge(input int ch);
    if (is_latching(ch)) m_lat[ch] = 1'b1;
    if (ch >= 4 && ch < 8) begin
      if (m_busy[ch-4]) m_err[ch-4] = 1'b1;
      m_busy[ch-4] = 1'b1;
      m_evt = 2'(ch-4);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_en = 1; reg_we = 0; reg_addr = a;
    @(negedge clk);
    reg_en = 0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic check_all(input string ctx);
    logic [15:0] d;
    rd(2'd0, d); chk({"R2 R3 latch ", ctx}, d, exp_rd(0));
    rd(2'd2, d); chk({"R6 R8 busy/err reg ", ctx}, d, exp_rd(2));
    rd(2'd1, d); chk({"R5 out reg ", ctx}, d, exp_rd(1));
    chk({"R6 busy_o ", ctx}, busy_o, m_busy);
    chk({"R8 ovl_err_o ", ctx}, ovl_err_o, m_err);
    chk({"R7 idle_o ", ctx}, idle_o, (m_busy == 0));
    chk({"R9 evt_valid_o ", ctx}, evt_valid_o, (m_busy != 0));
    if (m_busy != 0) chk({"R9 evt_type_o ", ctx}, evt_type_o, m_evt);
  endtask

  task automatic pulse(input int ch, input int hold);
    @(negedge clk);
    trig_in[ch] = 1'b1;
    repeat (hold) @(negedge clk);
    trig_in[ch] = 1'b0;
    if (ch != 1) model_edge(ch);
    settle();
  endtask

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 busy", busy_o, 0);
    chk("R1 idle", idle_o, 1);
    chk("R1 out", out_reg_o, 0);
    chk("R1 err", ovl_err_o, 0);
    rst_n = 1'b1;
    settle();
    check_all("after reset R1");

    // R2 latch then W1C clear, R3
    pulse(2, 2);
    check_all("pulse ch2");
    wr(2'd0, 16'h0004); m_lat[2] = 0;
    check_all("clear ch2 R3");

    // R2 held high sets once
    @(negedge clk); trig_in[3] = 1;
    settle(); m_lat[3] = 1;
    wr(2'd0, 16'h0008); m_lat[3] = 0;
    settle();
    rd(2'd0, d); chk("R2 no re-set while held", d[3], 0);
    trig_in[3] = 0; settle();

    // R4 status channel, R10 read latency
    @(negedge clk); trig_in[12] = 1; settle();
    rd(2'd3, d); chk("R4 live level ch12", d[12], 1);
    chk("R10 rdata after read", reg_rdata, d);
    rd(2'd0, d); chk("R4 ch12 not latched", d[12], 0);
    trig_in[12] = 0; settle();

    // R5 trig_in[1] ignored, loopback sets latch 1
    pulse(1, 3);
    rd(2'd0, d); chk("R5 trig_in1 ignored", d[1], 0);
    wr(2'd1, 16'h0001); m_out = 16'h0001; m_lat[1] = 1; settle();
    chk("R5 out_reg_o", out_reg_o, 16'h0001);
    check_all("loopback R5");
    wr(2'd1, 16'h0000); m_out = 0; settle();
    wr(2'd0, 16'h0002); m_lat[1] = 0;

    // R6 busy, R8 overlap, R9 event type
    pulse(5, 2);
    check_all("calib R6");
    pulse(5, 2);
    check_all("calib overlap R8");
    wr(2'd2, 16'h00F2); m_busy[1] = 0; m_err = 0;
    check_all("busy/err clear R6 R8");

    // R9 tie: classes 1 and 3 together -> type 1
    @(negedge clk); trig_in[5] = 1; trig_in[7] = 1;
    repeat (2) @(negedge clk); trig_in[5] = 0; trig_in[7] = 0;
    model_edge(7); model_edge(5); settle();
    check_all("tie R9");
    chk("R9 tie lowest", evt_type_o, 2'd1);

    // R3 set wins over coincident clear
    wr(2'd0, 16'h0008); m_lat[3] = 0;
    @(negedge clk); trig_in[3] = 1;     // after E0
    @(negedge clk);                     // after E1
    reg_en = 1; reg_we = 1; reg_addr = 2'd0; reg_wdata = 16'h0008;
    @(negedge clk);                     // after E2; clear sampled at E3
    @(negedge clk);
    reg_en = 0; reg_we = 0;
    rd(2'd0, d); chk("R3 set wins", d[3], 1);
    m_lat[3] = 1;
    trig_in[3] = 0; settle();

    // constrained random mix
    for (int it = 0; it < 300; it++) begin
      int act;
      int ch;
      logic [15:0] v;
      act = $urandom_range(0, 4);
      case (act)
        0, 1: begin
          ch = $urandom_range(0, 7);
          pulse(ch, $urandom_range(1, 4));
        end
        2: begin
          v = 16'($urandom);
          wr(2'd0, v); m_lat &= ~v;
        end
        3: begin
          v = 16'($urandom);
          wr(2'd2, v); m_busy &= ~v[3:0]; m_err &= ~v[7:4];
        end
        default: begin
          v = 16'($urandom);
          if (!m_out[0] && v[0]) m_lat[1] = 1'b1;
          wr(2'd1, v); m_out = v; settle();
        end
      endcase
      check_all($sformatf("rand it=%0d", it));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7);
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule